// File: doc/BRIEF.md
# HI/LO Multiply/Divide Unit with Latency Model

This block holds the HI and LO result registers of a 32-bit RISC core, together with the arithmetic that writes them. It computes signed and unsigned 32x32 products into a 64-bit HI:LO pair. It computes signed and unsigned quotients into LO and remainders into HI, and it lets the core load HI or LO directly from a register value. Results are written into HI/LO at the issuing clock edge.

Separately, the block models how long the real arithmetic would take. A down-counter is loaded with an operation- and operand-dependent latency. When the core asks to read HI or LO (a move-from request) while that counter is running, the block raises a stall until the counter expires. A global enable turns the stall model off, so that reads never wait.

The control is a two-state machine:
- `ST_IDLE`: counter at zero, not busy.
- `ST_BUSY`: counter running.

It has four transitions:
- `ST_IDLE` to `ST_BUSY` on an issued multiply or divide.
- `ST_BUSY` to `ST_BUSY` on a re-issue, which reloads the counter.
- `ST_BUSY` to `ST_BUSY` while the count is above one, which decrements it.
- `ST_BUSY` to `ST_IDLE` when the count is one and nothing is issued.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `hi` and `lo` are zero and `busy` and `rd_stall` are low.
- R2: With `start` high, `op`=0 (signed multiply) or `op`=1 (unsigned multiply) writes the 64-bit product of `rs` and `rt` at that clock edge: the low word goes to `lo` and the high word to `hi`. Operand 0 sign-extends both operands and operand 1 zero-extends them.
- R3: With `start` high, `op`=2 (signed divide) or `op`=3 (unsigned divide) writes the quotient of `rs`/`rt` into `lo` and the remainder into `hi`. A signed quotient truncates toward zero, and a signed remainder takes the sign of `rs`.
- R4: A divide by zero writes `hi`=`rs`. The unsigned form gives `lo`=0xFFFFFFFF. The signed form gives `lo`=1 when `rs` is negative and `lo`=0xFFFFFFFF otherwise.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF gives `lo`=0x80000000 and `hi`=0, with no other effect.
- R6: Every divide makes `busy` high for exactly 37 cycles after the issuing edge.
- R7: An unsigned multiply makes `busy` high for 7+(2-floor(z/11))*4 cycles, where z is the count of leading zeros of (`rs`|1).
- R8: A signed multiply uses the same latency formula, with z taken from ((`rs` XOR (`rs` shifted right arithmetically by 21)) | 1).
- R9: `rd_stall` is high in a cycle exactly when `rd_req` and `stall_en` are high and `busy` is high. It drops in the first cycle after the count expires.
- R10: With `stall_en` low, `rd_stall` stays low whatever `rd_req` and `busy` are.
- R11: `op`=4 loads `hi` from `rs` and `op`=5 loads `lo` from `rs` at the issuing edge. Neither changes the other register or the running busy count.
- R12: A multiply or divide issued while `busy` is high replaces `hi`/`lo` and restarts the count with the new operation's latency.
- R13: `op` values 6 and 7, and any cycle with `start` low, change neither `hi`, `lo` nor the busy count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for `op` |
| op | input | 3 | Operation code: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 load HI, 5 load LO |
| rs | input | 32 | First operand / value for direct loads |
| rt | input | 32 | Second operand |
| stall_en | input | 1 | Enables the stall model |
| rd_req | input | 1 | Move-from HI/LO request this cycle |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| busy | output | 1 | Latency counter running |
| rd_stall | output | 1 | Hold the move-from request |

## Verification
The embedded assertions check several properties on every cycle:
- The counter stays within the divide latency.
- `busy` only falls when the count reaches one.
- The count steps down by one whenever nothing is issued, including across direct HI/LO loads.
- An unsigned multiply lands its product one edge later.
- Ignored op codes leave HI/LO untouched.
- Stalls are absent when the model is off.

Only the bench scenarios can show the remaining behaviours: the exact latency per operand band, the divide corner results, the restart on re-issue, and the stall releasing in the right cycle. The bench does this by comparing every output, every cycle, against a behavioural model.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_DIV_S  = 3'd2,
        OP_DIV_U  = 3'd3,
        OP_SET_HI = 3'd4,
        OP_SET_LO = 3'd5
    } md_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } md_state_e;

endpackage

// File: rtl/muldiv_latency.sv
module muldiv_latency
    import muldiv_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int MUL_BASE   = 7,
    parameter int MUL_STEP   = 4,
    parameter int LZ_BAND    = 11,
    parameter int SGN_SHIFT  = 21,
    parameter int DIV_CYCLES = 37,
    parameter int CW         = 6
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] rs,
    output logic [CW-1:0]   lat
);
    localparam int BANDS = (XLEN - 1) / LZ_BAND;

    logic [XLEN-1:0] probe;
    logic            found;
    int              lz;

    always_comb begin
        if (op == OP_MUL_S)
            probe = (rs ^ XLEN'($signed(rs) >>> SGN_SHIFT)) | XLEN'(1);
        else
            probe = rs | XLEN'(1);
        lz    = 0;
        found = 1'b0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (!found) begin
                if (probe[i]) found = 1'b1;
                else          lz    = lz + 1;
            end
        end
        if (op == OP_DIV_S || op == OP_DIV_U)
            lat = CW'(DIV_CYCLES);
        else
            lat = CW'(MUL_BASE + (BANDS - lz / LZ_BAND) * MUL_STEP);
    end

endmodule

// File: rtl/muldiv_arith.sv
module muldiv_arith
    import muldiv_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] rs,
    input  logic [XLEN-1:0] rt,
    output logic [XLEN-1:0] res_hi,
    output logic [XLEN-1:0] res_lo
);
    localparam logic [XLEN-1:0] ALL_ONES = '1;
    localparam logic [XLEN-1:0] MIN_NEG  = {1'b1, {(XLEN-1){1'b0}}};

    logic              sx;
    logic [2*XLEN-1:0] prod;

    assign sx   = (op == OP_MUL_S);
    assign prod = {{XLEN{sx & rs[XLEN-1]}}, rs} * {{XLEN{sx & rt[XLEN-1]}}, rt};

    always_comb begin
        res_hi = prod[2*XLEN-1:XLEN];
        res_lo = prod[XLEN-1:0];
        if (op == OP_DIV_S) begin
            if (rt == '0) begin
                res_hi = rs;
                res_lo = rs[XLEN-1] ? XLEN'(1) : ALL_ONES;
            end else if (rs == MIN_NEG && rt == ALL_ONES) begin
                res_hi = '0;
                res_lo = MIN_NEG;
            end else begin
                res_hi = XLEN'($signed(rs) % $signed(rt));
                res_lo = XLEN'($signed(rs) / $signed(rt));
            end
        end else if (op == OP_DIV_U) begin
            if (rt == '0) begin
                res_hi = rs;
                res_lo = ALL_ONES;
            end else begin
                res_hi = rs % rt;
                res_lo = rs / rt;
            end
        end
    end

endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int CW      = 6,
    parameter int MAX_LAT = 37
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [CW-1:0] lat,
    input  logic          stall_en,
    input  logic          rd_req,
    output logic          busy,
    output logic          rd_stall
);
    md_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue) begin
                    state_d = ST_BUSY;
                    cnt_d   = lat;
                end
            end
            ST_BUSY: begin
                if (issue) begin
                    cnt_d = lat;
                end else if (cnt_q == CW'(1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy     = (state_q == ST_BUSY);
        rd_stall = busy && stall_en && rd_req;
    end

    // R6: the count never exceeds the longest latency
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_LAT));

    // R6: busy only ends once the count has run down to one
    a_r6_fall_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == CW'(1)));

    // R11: with nothing issued (direct loads included) the count steps down by one
    a_r11_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !issue && cnt_q != CW'(1)) |=> (cnt_q == CW'($past(cnt_q) - CW'(1))));

    // R12: an issue always leaves the unit busy
    a_r12_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> busy);

    // R10: no stall when the model is off
    a_r10_no_stall_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_en |-> !rd_stall);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int MUL_BASE   = 7,
    parameter int MUL_STEP   = 4,
    parameter int LZ_BAND    = 11,
    parameter int SGN_SHIFT  = 21,
    parameter int DIV_CYCLES = 37
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] rs,
    input  logic [XLEN-1:0] rt,
    input  logic            stall_en,
    input  logic            rd_req,
    output logic [XLEN-1:0] hi,
    output logic [XLEN-1:0] lo,
    output logic            busy,
    output logic            rd_stall
);
    localparam int CW = $clog2(DIV_CYCLES + 1);

    logic            issue;
    logic [CW-1:0]   lat;
    logic [XLEN-1:0] res_hi, res_lo;

    assign issue = start && (op == OP_MUL_S || op == OP_MUL_U ||
                             op == OP_DIV_S || op == OP_DIV_U);

    muldiv_latency #(
        .XLEN(XLEN), .MUL_BASE(MUL_BASE), .MUL_STEP(MUL_STEP),
        .LZ_BAND(LZ_BAND), .SGN_SHIFT(SGN_SHIFT),
        .DIV_CYCLES(DIV_CYCLES), .CW(CW)
    ) u_lat (
        .op(op), .rs(rs), .lat(lat)
    );

    muldiv_arith #(.XLEN(XLEN)) u_arith (
        .op(op), .rs(rs), .rt(rt), .res_hi(res_hi), .res_lo(res_lo)
    );

    muldiv_ctrl #(.CW(CW), .MAX_LAT(DIV_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .issue(issue), .lat(lat),
        .stall_en(stall_en), .rd_req(rd_req),
        .busy(busy), .rd_stall(rd_stall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else if (start) begin
            case (op)
                OP_MUL_S, OP_MUL_U, OP_DIV_S, OP_DIV_U: begin
                    hi <= res_hi;
                    lo <= res_lo;
                end
                OP_SET_HI: hi <= rs;
                OP_SET_LO: lo <= rs;
                default: ;
            endcase
        end
    end

    // R2: unsigned product lands on the edge after issue
    a_r2_multu_product: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_MUL_U) |=>
        ({hi, lo} == ({{XLEN{1'b0}}, $past(rs)} * {{XLEN{1'b0}}, $past(rt)})));

    // R11: loading HI leaves LO alone
    a_r11_sethi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == OP_SET_HI) |=> (lo == $past(lo)));

    // R13: unused op codes leave both registers alone
    a_r13_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[2] && op[1]) |=> (hi == $past(hi) && lo == $past(lo)));

endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] rs = '0, rt = '0;
    logic        stall_en = 1'b0;
    logic        rd_req = 1'b0;
    logic [31:0] hi, lo;
    logic        busy, rd_stall;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_hi = '0, m_lo = '0;
    int          m_cnt = 0;
    string       tag_res = "R1";
    string       tag_lat = "R1";

    always #4 clk = ~clk;  // 125 MHz

    muldiv_unit u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs(rs), .rt(rt),
        .stall_en(stall_en), .rd_req(rd_req),
        .hi(hi), .lo(lo), .busy(busy), .rd_stall(rd_stall)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int exp_lat(logic [2:0] o, logic [31:0] a);
        logic [31:0] p;
        int z;
        if (o == 3'd2 || o == 3'd3) return 37;
        if (o == 3'd0) p = a ^ 32'($signed(a) >>> 21);
        else           p = a;
        p = p | 32'd1;
        z = 0;
        while (p[31 - z] == 1'b0) z++;
        return 7 + (2 - z / 11) * 4;
    endfunction

    task automatic model_edge(logic s, logic [2:0] o, logic [31:0] a, logic [31:0] b);
        longint sa, sb;
        longint unsigned ua, ub, pr;
        if (s && o <= 3'd3) begin
            m_cnt = exp_lat(o, a);
            tag_lat = (o == 3'd0) ? "R8" : (o == 3'd1) ? "R7" : "R6";
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            ua = {32'd0, a};
            ub = {32'd0, b};
            case (o)
                3'd0: begin pr = longint'(sa * sb); {m_hi, m_lo} = pr; tag_res = "R2"; end
                3'd1: begin pr = ua * ub; {m_hi, m_lo} = pr; tag_res = "R2"; end
                3'd2: begin
                    if (b == 0) begin
                        m_hi = a; m_lo = (sa < 0) ? 32'd1 : 32'hFFFF_FFFF; tag_res = "R4";
                    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
                        m_hi = 0; m_lo = 32'h8000_0000; tag_res = "R5";
                    end else begin
                        m_lo = 32'(sa / sb); m_hi = 32'(sa % sb); tag_res = "R3";
                    end
                end
                default: begin
                    if (b == 0) begin m_hi = a; m_lo = 32'hFFFF_FFFF; tag_res = "R4"; end
                    else begin m_lo = 32'(ua / ub); m_hi = 32'(ua % ub); tag_res = "R3"; end
                end
            endcase
        end else begin
            if (m_cnt > 0) m_cnt--;
            if (s && o == 3'd4) begin m_hi = a; tag_res = "R11"; end
            else if (s && o == 3'd5) begin m_lo = a; tag_res = "R11"; end
            else if (s) tag_res = "R13";
        end
    endtask

    // one clock: drive, compare every output, then advance the model over the edge
    task automatic step(logic s, logic [2:0] o, logic [31:0] a, logic [31:0] b,
                        logic rq, logic se);
        @(negedge clk);
        start = s; op = o; rs = a; rt = b; rd_req = rq; stall_en = se;
        #1;
        chk({tag_res, " hi"}, hi, m_hi);
        chk({tag_res, " lo"}, lo, m_lo);
        chk({tag_lat, " busy"}, {31'd0, busy}, {31'd0, m_cnt > 0});
        chk(se ? "R9 rd_stall" : "R10 rd_stall", {31'd0, rd_stall},
            {31'd0, rq && se && (m_cnt > 0)});
        @(posedge clk);
        #1;
        model_edge(s, o, a, b);
    endtask

    task automatic idle(int n, logic rq, logic se);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, rq, se);
    endtask

    task automatic run_op(logic [2:0] o, logic [31:0] a, logic [31:0] b, int wait_n);
        step(1'b1, o, a, b, 1'b0, 1'b1);
        idle(wait_n, 1'b1, 1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 hi", hi, 32'd0);
        chk("R1 lo", lo, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 rd_stall", {31'd0, rd_stall}, 32'd0);

        // R7: unsigned multiply in each latency band
        run_op(3'd1, 32'd5, 32'd7, 9);
        run_op(3'd1, 32'h0010_0000, 32'h0000_1003, 13);
        run_op(3'd1, 32'h8000_0000, 32'hFFFF_FFFF, 17);
        // R8 / R2: signed multiply in each band, negative operands
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 9);
        run_op(3'd0, 32'h4000_0000, 32'h0000_0010, 17);
        run_op(3'd0, 32'hFFF0_0000, 32'h1234_5678, 13);
        // R3: divides with mixed signs
        run_op(3'd2, 32'd7, 32'd2, 39);
        run_op(3'd2, 32'hFFFF_FFF9, 32'd2, 39);
        run_op(3'd2, 32'd7, 32'hFFFF_FFFE, 39);
        run_op(3'd3, 32'hFFFF_FFF9, 32'd2, 39);
        // R4: divide by zero
        run_op(3'd2, 32'hFFFF_FF00, 32'd0, 39);
        run_op(3'd2, 32'd1234, 32'd0, 39);
        run_op(3'd3, 32'hDEAD_BEEF, 32'd0, 39);
        // R5: most negative over minus one
        run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 39);

        // R11: direct loads mid-count leave the count running
        step(1'b1, 3'd2, 32'd100, 32'd3, 1'b0, 1'b1);
        idle(4, 1'b1, 1'b1);
        step(1'b1, 3'd4, 32'hAAAA_5555, 32'd0, 1'b1, 1'b1);
        step(1'b1, 3'd5, 32'h1357_9BDF, 32'd0, 1'b1, 1'b1);
        idle(34, 1'b1, 1'b1);
        // R10: stall model off during a divide
        step(1'b1, 3'd3, 32'd50, 32'd7, 1'b1, 1'b0);
        idle(38, 1'b1, 1'b0);
        // R12: re-issue while busy restarts with the shorter latency
        step(1'b1, 3'd2, 32'd99, 32'd9, 1'b0, 1'b1);
        idle(10, 1'b1, 1'b1);
        step(1'b1, 3'd1, 32'd3, 32'd3, 1'b1, 1'b1);
        idle(9, 1'b1, 1'b1);
        // R13: unused op codes and start low
        step(1'b1, 3'd6, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
        step(1'b1, 3'd7, 32'h0F0F_0F0F, 32'd1, 1'b0, 1'b1);
        step(1'b0, 3'd4, 32'h1111_1111, 32'd1, 1'b0, 1'b1);
        idle(2, 1'b0, 1'b1);

        // mixed traffic against the model (R2 R3 R9 R12 R13)
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, b;
            case ($urandom % 6)
                0: a = 32'h8000_0000;
                1: a = 32'd0;
                2: a = 32'hFFFF_FFFF;
                default: a = $urandom;
            endcase
            case ($urandom % 5)
                0: b = 32'd0;
                1: b = 32'hFFFF_FFFF;
                default: b = $urandom;
            endcase
            step(($urandom % 4) == 0, 3'($urandom % 8), a, b,
                 1'($urandom), ($urandom % 4) != 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule